// File: doc/BRIEF.md
# Page Write Staging Buffer

This block sits between a serial-bus front end and a non-volatile memory array. It collects the bytes of one page write before any of them reach the array. The front end first presents the starting word address. It then hands over received data bytes one at a time, each qualified by a strobe. The block keeps every byte in a small page buffer and advances a pointer that moves only inside the current page. A transfer that sends more bytes than the page holds therefore wraps to the start of the page and overwrites what it stored earlier. It never spills into the next page.

When the front end sees the end of the transfer, it raises a commit request. The block then walks all page offsets, one per clock. For each offset that was loaded, it issues a write to the array port. After that it holds `busy` for a programmable write time. While `busy` is high, every new strobe is ignored. Offsets that were never loaded are not written, so their array contents survive. A single-byte write goes through the same path as a page with one loaded entry.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and no offset is marked as loaded, so a commit issued straight after reset starts no write cycle.
- R2: A pulse on `addr_load` while `busy` is low takes `addr_in[ADDR_W-1:OFS_W]` (bits 10:4 by default) as the page and `addr_in[OFS_W-1:0]` (bits 3:0) as the next offset. When `addr_load` and `byte_stb` are high in the same cycle, the address is taken and the byte is dropped.
- R3: Each accepted byte advances only the low OFS_W bits of the address, wrapping from 15 to 0. The page bits stay as loaded for the whole transfer.
- R4: When more than 16 bytes arrive before commit, each byte beyond the sixteenth replaces the byte held at its offset. The array receives only the last value sent for each offset.
- R5: `mem_we` is never high while `busy` is low. Nothing reaches the array before a commit.
- R6: A commit while `busy` is low and at least one offset is loaded sets `busy` on the next clock and then scans offsets 0 to 15 on consecutive cycles. On each cycle whose offset is loaded, it drives `mem_we` high with `mem_addr` = {page, offset} and that offset's byte. Array locations whose offsets were not loaded keep their contents.
- R7: After such a commit, `busy` stays high for exactly 16 + WRITE_CYCLES clocks.
- R8: While `busy` is high, `byte_stb`, `addr_load` and `commit` are ignored. They change neither the buffer, nor the pointer, nor the sequence in progress.
- R9: When the write cycle ends, every loaded mark is cleared. A later commit with no new bytes starts nothing.
- R10: A commit with no offset loaded leaves `busy` low and issues no array write.
- R11: A single byte followed by commit writes exactly one array location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Strobe: take `addr_in` as the start word address |
| addr_in | input | ADDR_W | Start word address |
| byte_stb | input | 1 | Strobe: `byte_in` holds a received data byte |
| byte_in | input | DATA_W | Received data byte |
| commit | input | 1 | End-of-transfer request that starts the write cycle |
| busy | output | 1 | High during copy and write time |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The assertions assume that `commit` is never raised in the same cycle as `byte_stb` or `addr_load`, and that the reset lasts at least one clock edge. The stimulus keeps to this by issuing each strobe in its own single-cycle pulse with idle cycles between pulses. The only exception is a burst during `busy`, where all three strobes are raised together on purpose to exercise the ignore rule while the block cannot act on any of them. Random transfers draw their start address and length (1 to 40 bytes) from a seeded generator. Directed cases cover the boundaries: a page start at offset 15, an exact 16-byte page, an overrun, and an empty commit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_COPY = 2'd1,
    SQ_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pwb_pointer.sv
module pwb_pointer #(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 4,
  localparam int PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv,
  output logic [PAGE_W-1:0] page,
  output logic [OFS_W-1:0]  ofs
);
  logic [PAGE_W-1:0] page_d;
  logic [OFS_W-1:0]  ofs_d;
  logic              en;

  always_comb begin
    page_d = page;
    ofs_d  = ofs;
    en     = load | adv;
    if (load) begin
      page_d = addr_in[ADDR_W-1:OFS_W];
      ofs_d  = addr_in[OFS_W-1:0];
    end else if (adv) begin
      ofs_d  = ofs + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0;
      ofs  <= '0;
    end else if (en) begin
      page <= page_d;
      ofs  <= ofs_d;
    end
  end

  AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> ofs == OFS_W'($past(ofs) + 1'b1)); // R3
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(page)); // R3
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 4,
  localparam int DEPTH = 1 << OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  mask
);
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [DEPTH-1:0]             hit;
  logic [DEPTH-1:0]             mask_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign hit[g] = wr_en && (wr_ofs == OFS_W'(g));
  end

  always_comb begin
    mask_d = mask;
    if (clr)        mask_d = '0;
    else if (wr_en) mask_d = mask | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) data_q[i] <= wr_data;
    end
  end

  assign rd_data = data_q[rd_ofs];

  AST_MARK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mask[$past(wr_ofs)]); // R4
  AST_MARK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> mask == '0); // R9
endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
  import pwb_pkg::*;
#(
  parameter int OFS_W        = 4,
  parameter int WRITE_CYCLES = 40,
  localparam int DEPTH = 1 << OFS_W,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [DEPTH-1:0] mask,
  output logic             busy,
  output logic [OFS_W-1:0] scan,
  output logic             we,
  output logic             clr
);
  seq_state_e       state_q, state_d;
  logic [OFS_W-1:0] scan_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             scan_en, cnt_en;

  always_comb begin
    state_d = state_q;
    scan_d  = scan;
    cnt_d   = cnt_q;
    scan_en = 1'b0;
    cnt_en  = 1'b0;
    clr     = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (commit && (|mask)) begin
          state_d = SQ_COPY;
          scan_d  = '0;
          scan_en = 1'b1;
        end
      end
      SQ_COPY: begin
        scan_d  = scan + 1'b1;
        scan_en = 1'b1;
        if (scan == {OFS_W{1'b1}}) begin
          state_d = SQ_HOLD;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SQ_HOLD: begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == CNT_W'(WRITE_CYCLES - 1)) begin
          state_d = SQ_IDLE;
          clr     = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       scan <= '0;
    else if (scan_en) scan <= scan_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (state_q != SQ_IDLE);
  assign we   = (state_q == SQ_COPY) && mask[scan];

  AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mask == '0 && !busy) |=> !busy); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mask != '0 && !busy) |=> busy); // R6
  AST_END_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> mask == '0); // R9
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int OFS_W        = 4,
  parameter int WRITE_CYCLES = 40,
  localparam int DEPTH  = 1 << OFS_W,
  localparam int PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              commit,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              ld_ok;
  logic              byte_ok;
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  wofs;
  logic [OFS_W-1:0]  scan;
  logic [DEPTH-1:0]  mask;
  logic              clr;

  assign ld_ok   = addr_load && !busy;
  assign byte_ok = byte_stb && !busy && !addr_load;

  pwb_pointer #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ld_ok), .addr_in(addr_in),
    .adv(byte_ok), .page(page), .ofs(wofs)
  );

  pwb_store #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(byte_ok), .wr_ofs(wofs),
    .wr_data(byte_in), .clr(clr), .rd_ofs(scan), .rd_data(mem_wdata),
    .mask(mask)
  );

  pwb_sequencer #(.OFS_W(OFS_W), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .mask(mask),
    .busy(busy), .scan(scan), .we(mem_we), .clr(clr)
  );

  assign mem_addr = {page, scan};

  AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr) |=> $stable(mask)); // R8
  AST_PAGE_FIXED_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(page)); // R8
endmodule

// File: tb/page_write_buffer_test.sv
`timescale 1ns/1ps
module page_write_buffer_test;
  localparam int AW = 11, DW = 8, OW = 4, WC = 40, PG = 16, MEMN = 2048;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, addr_load, byte_stb, commit;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] byte_in;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  page_write_buffer #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .commit(commit), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic [DW-1:0] mem [MEMN];
  logic [DW-1:0] exp_mem [MEMN];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int total = 0, bad = 0;
  bit done = 0;

  // independent staging model
  logic [DW-1:0] st_d [PG];
  bit            st_v [PG];
  logic [6:0]    m_page;
  int            m_ofs;

  int we_cnt, we_idle, we_wrong_page;
  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      we_cnt++;
      if (!busy) we_idle++;
      if (mem_addr[10:4] != m_page) we_wrong_page++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int loaded_count();
    int n = 0;
    for (int i = 0; i < PG; i++) if (st_v[i]) n++;
    return n;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    @(negedge clk); addr_load = 1'b1; addr_in = a;
    @(negedge clk); addr_load = 1'b0;
    m_page = a[10:4]; m_ofs = int'(a[3:0]);
    we_cnt = 0; we_idle = 0; we_wrong_page = 0;
  endtask

  task automatic send_byte(input logic [DW-1:0] d);
    @(negedge clk); byte_stb = 1'b1; byte_in = d;
    @(negedge clk); byte_stb = 1'b0;
    st_d[m_ofs] = d; st_v[m_ofs] = 1'b1;
    m_ofs = (m_ofs + 1) % PG;
  endtask

  task automatic compare_mem(input string req);
    int diffs = 0, first = -1;
    for (int i = 0; i < MEMN; i++) begin
      if (mem[i] !== exp_mem[i]) begin
        diffs++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = 0;
    check(diffs == 0, req, $sformatf("array contents, first mismatch @%0d", first),
          longint'(mem[first]), longint'(exp_mem[first]));
  endtask

  // commit; poke=1 drives all strobes during busy
  task automatic do_commit(input string req, input bit poke);
    int nv, blen, exp_len;
    nv = loaded_count();
    exp_len = (nv > 0) ? PG + WC : 0;
    check(we_cnt == 0, "R5", "writes before commit", we_cnt, 0);
    for (int i = 0; i < PG; i++) begin
      if (st_v[i]) exp_mem[{m_page, 4'(i)}] = st_d[i];
      st_v[i] = 1'b0;
    end
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    blen = 0;
    while (busy && blen < 1000) begin
      blen++;
      if (poke && blen == 3) begin
        byte_stb = 1'b1; byte_in = 8'hA5; addr_load = 1'b1;
        addr_in = 11'h7F3; commit = 1'b1;
      end else begin
        byte_stb = 1'b0; addr_load = 1'b0; commit = 1'b0;
      end
      @(negedge clk);
    end
    byte_stb = 1'b0; addr_load = 1'b0; commit = 1'b0;
    idle(2);
    check(blen == exp_len, "R7", "busy length", blen, exp_len);
    check(we_cnt == nv, (nv == 0) ? "R10" : "R6", "array write count", we_cnt, nv);
    check(we_idle == 0, "R5", "writes with busy low", we_idle, 0);
    check(we_wrong_page == 0, "R3", "writes outside loaded page", we_wrong_page, 0);
    compare_mem(req);
    we_cnt = 0; we_idle = 0; we_wrong_page = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; addr_load = 1'b0; byte_stb = 1'b0; commit = 1'b0;
    addr_in = '0; byte_in = '0; m_page = '0; m_ofs = 0;
    we_cnt = 0; we_idle = 0; we_wrong_page = 0;
    for (int i = 0; i < PG; i++) begin st_v[i] = 1'b0; st_d[i] = '0; end
    for (int i = 0; i < MEMN; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
    do_commit("R1", 1'b0);               // empty mask after reset

    // R11: single byte write
    load_addr(11'h123);
    send_byte(8'h5C);
    do_commit("R11", 1'b0);

    // R2/R6: full page from offset 0
    load_addr(11'h200);
    for (int i = 0; i < PG; i++) send_byte(8'(8'h10 + i));
    do_commit("R6", 1'b0);

    // R3: start at offset 15, wrap to 0 and 1
    load_addr(11'h34F);
    send_byte(8'hE1); send_byte(8'hE2); send_byte(8'hE3);
    do_commit("R3", 1'b0);

    // R4: overrun, 20 bytes from offset 5
    load_addr(11'h3A5);
    for (int i = 0; i < 20; i++) send_byte(8'(8'h80 + i));
    do_commit("R4", 1'b0);

    // R10: empty commit
    do_commit("R10", 1'b0);

    // R2: addr_load and byte_stb together -> byte dropped
    load_addr(11'h041);
    @(negedge clk); addr_load = 1'b1; addr_in = 11'h048; byte_stb = 1'b1; byte_in = 8'h99;
    @(negedge clk); addr_load = 1'b0; byte_stb = 1'b0;
    m_page = 7'h04; m_ofs = 8;
    send_byte(8'h3D);
    do_commit("R2", 1'b0);

    // R8/R9: strobes during busy ignored, mask cleared afterwards
    load_addr(11'h5E2);
    send_byte(8'h11); send_byte(8'h22);
    do_commit("R8", 1'b1);
    do_commit("R9", 1'b0);               // nothing loaded: no cycle
    send_byte(8'h33);                     // continues at old pointer
    do_commit("R8", 1'b0);

    // random transfers
    for (int t = 0; t < 25; t++) begin
      int n;
      load_addr(11'($urandom));
      n = $urandom_range(1, 40);
      for (int k = 0; k < n; k++) begin
        send_byte(8'($urandom));
        if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
      end
      do_commit("R6", 1'b0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule